// File: doc/BRIEF.md
# Configurable Buffer and Decoder Cell

This block is a purely combinational routing-and-logic cell. It has ten bit lanes. Every lane has a left input and output, a right input and output, and a central input that comes from a neighbouring logic unit. The lanes are split into three groups:

| Group | Lanes |
|---|---|
| A | 3:0 |
| B | 7:4 |
| C | 9:8 |

A static configuration word gives each group one of two roles:

- **Buffer.** The group drives one of its lane directions.
- **Decoder.** The group's central inputs feed a product term of a small AND/OR tree. The tree has one output, `dec_out`, which can be inverted.

Tri-state drivers are modelled as explicit output-enable vectors. A disabled lane reads as 0 on its data output. The two four-bit groups can take their enable from several sources:

- a shared control pin,
- the same pin inverted,
- a permanent on,
- the decode output, optionally gated by the shared pin.

Because of this, one nibble can follow the shared pin while the other follows the decoder. The two-bit group has no enable and always drives when it is buffering.

The cell has no clock and no data stream with flow control. Every pin is plain configuration or plain data, and all outputs settle in the same evaluation as the inputs.

Top module: `bufdec_cell`

## Requirements
- R1: Bit k of `grp_mode` sets group k to decoder (bit 0 → lanes 3:0, bit 1 → lanes 7:4, bit 2 → lanes 9:8); all eight values are legal. A decoder group drives no lane: all its enable bits are 0.
- R2: For a buffering, enabled group, the 3-bit route code selects the driving path. The codes are:
  - 0: right output takes left input.
  - 1: left output takes right input.
  - 2: left output takes central input.
  - 3: right output takes central input.
  - 4: both outputs take central input.
  - 5, 6, 7: nothing is driven.
- R3: Every lane output whose enable bit is 0 reads 0.
- R4: A nibble's 2-bit enable select works as follows: 0 enables when `oe_ctl`=1; 1 enables when `oe_ctl`=0; 2 always enables; 3 enables from `dec_out`.
- R5: The two-bit group, when buffering, drives regardless of `oe_ctl`.
- R6: Each decoder group forms the AND of its central inputs. Buffer groups are excluded from the tree: they give 1 to an AND combiner and 0 to an OR combiner.
- R7: `comb_or`=0 combines the group terms with AND and `comb_or`=1 combines them with OR. `dec_inv`=1 inverts the result to form `dec_out`.
- R8: With every group buffering, `dec_out` is a constant: 1 for AND with no inversion, 0 for OR with no inversion, and the complement of these when inverted.
- R9: With enable select 3 and `dec_gate`=1, the nibble's enable is `dec_out` AND `oe_ctl`.
- R10: The two nibbles' enables are independent, so one can follow `oe_ctl` while the other follows `dec_out` in the same configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| grp_mode | input | 3 | Per-group role, 1 = decoder |
| route_a | input | 3 | Route code, lanes 3:0 |
| route_b | input | 3 | Route code, lanes 7:4 |
| route_c | input | 3 | Route code, lanes 9:8 |
| ensel_a | input | 2 | Enable select, lanes 3:0 |
| ensel_b | input | 2 | Enable select, lanes 7:4 |
| dec_gate | input | 1 | Gate decoder-sourced enables with `oe_ctl` |
| comb_or | input | 1 | Combiner type, 1 = OR |
| dec_inv | input | 1 | Invert decode result |
| oe_ctl | input | 1 | Shared tri-state control |
| l_in | input | 10 | Left-side lane inputs |
| r_in | input | 10 | Right-side lane inputs |
| c_in | input | 10 | Central lane inputs |
| l_out | output | 10 | Left-side lane outputs |
| l_oe | output | 10 | Left-side output enables |
| r_out | output | 10 | Right-side lane outputs |
| r_oe | output | 10 | Right-side output enables |
| dec_out | output | 1 | Decode output |

## Verification
The decode tree and a nibble's drivers can act in the same evaluation: in a mixed mode, one group's central inputs decide whether another group's buffers drive. The bench sets a nibble's enable select to the decoder while another group decodes. It then flips a single central input of the decoding group and checks that the buffering nibble's data and enable outputs switch together with `dec_out`. It also checks that the other nibble, which follows `oe_ctl`, stays unchanged. Every case is judged against a reference model written from the requirements, together with hand-derived decode values.

// File: rtl/bcell_pkg.sv
`timescale 1ns/1ps
package bcell_pkg;
  localparam int NIB_W  = 4;
  localparam int PAIR_W = 2;
  localparam int N_GRP  = 3;
  localparam int LANES  = 2 * NIB_W + PAIR_W;
  localparam int RT_W   = 3;
  localparam int ES_W   = 2;

  typedef enum logic [RT_W-1:0] {
    RT_L2R = 3'd0,
    RT_R2L = 3'd1,
    RT_C2L = 3'd2,
    RT_C2R = 3'd3,
    RT_C2B = 3'd4
  } route_e;

  typedef enum logic [ES_W-1:0] {
    ES_CTL   = 2'd0,
    ES_CTL_N = 2'd1,
    ES_ON    = 2'd2,
    ES_DEC   = 2'd3
  } ensel_e;
endpackage

// File: rtl/lane_group.sv
`timescale 1ns/1ps
module lane_group
  import bcell_pkg::*;
#(
  parameter int W = 4
) (
  input  logic            is_dec,
  input  logic [RT_W-1:0] route,
  input  logic            en,
  input  logic [W-1:0]    l_in,
  input  logic [W-1:0]    r_in,
  input  logic [W-1:0]    c_in,
  output logic [W-1:0]    l_out,
  output logic [W-1:0]    l_oe,
  output logic [W-1:0]    r_out,
  output logic [W-1:0]    r_oe
);
  logic         l_drv, r_drv, l_act, r_act;
  logic [W-1:0] l_src, r_src;

  always_comb begin
    l_drv = 1'b0;
    r_drv = 1'b0;
    l_src = '0;
    r_src = '0;
    case (route)
      RT_L2R: begin r_drv = 1'b1; r_src = l_in; end
      RT_R2L: begin l_drv = 1'b1; l_src = r_in; end
      RT_C2L: begin l_drv = 1'b1; l_src = c_in; end
      RT_C2R: begin r_drv = 1'b1; r_src = c_in; end
      RT_C2B: begin
        l_drv = 1'b1; l_src = c_in;
        r_drv = 1'b1; r_src = c_in;
      end
      default: ;
    endcase
    l_act = l_drv & en & ~is_dec;
    r_act = r_drv & en & ~is_dec;
    l_oe  = {W{l_act}};
    r_oe  = {W{r_act}};
    l_out = l_act ? l_src : '0;
    r_out = r_act ? r_src : '0;
  end

  // R1 / R3 guards at the group boundary
  always_comb begin
    a_r1_dec_silent: assert (!(is_dec && ((|l_oe) || (|r_oe))))
      else $error("decoder group drives a lane");
    a_r3_idle_zero: assert (((l_out & ~l_oe) == '0) && ((r_out & ~r_oe) == '0))
      else $error("disabled lane not zero");
  end
endmodule

// File: rtl/dec_tree.sv
`timescale 1ns/1ps
module dec_tree
  import bcell_pkg::*;
(
  input  logic [N_GRP-1:0] is_dec,
  input  logic [LANES-1:0] c_in,
  input  logic             use_or,
  input  logic             inv,
  output logic             dec
);
  localparam int OFF_B = NIB_W;
  localparam int OFF_C = 2 * NIB_W;

  logic [N_GRP-1:0] term, feed;
  logic             comb;

  always_comb begin
    term[0] = &c_in[0 +: NIB_W];
    term[1] = &c_in[OFF_B +: NIB_W];
    term[2] = &c_in[OFF_C +: PAIR_W];
    for (int g = 0; g < N_GRP; g++)
      feed[g] = is_dec[g] ? term[g] : ~use_or;
    comb = use_or ? (|feed) : (&feed);
    dec  = comb ^ inv;
  end
endmodule

// File: rtl/bufdec_cell.sv
`timescale 1ns/1ps
module bufdec_cell
  import bcell_pkg::*;
(
  input  logic [2:0] grp_mode,
  input  logic [2:0] route_a,
  input  logic [2:0] route_b,
  input  logic [2:0] route_c,
  input  logic [1:0] ensel_a,
  input  logic [1:0] ensel_b,
  input  logic       dec_gate,
  input  logic       comb_or,
  input  logic       dec_inv,
  input  logic       oe_ctl,
  input  logic [9:0] l_in,
  input  logic [9:0] r_in,
  input  logic [9:0] c_in,
  output logic [9:0] l_out,
  output logic [9:0] l_oe,
  output logic [9:0] r_out,
  output logic [9:0] r_oe,
  output logic       dec_out
);
  localparam int GW  [N_GRP] = '{NIB_W, NIB_W, PAIR_W};
  localparam int GOFF[N_GRP] = '{0, NIB_W, 2 * NIB_W};

  logic [RT_W-1:0]  rt  [N_GRP];
  logic [N_GRP-1:0] grp_en;
  logic             dec_en;

  dec_tree u_tree (
    .is_dec (grp_mode),
    .c_in   (c_in),
    .use_or (comb_or),
    .inv    (dec_inv),
    .dec    (dec_out)
  );

  function automatic logic pick_en(input logic [ES_W-1:0] sel, input logic ctl,
                                   input logic dsrc);
    case (ensel_e'(sel))
      ES_CTL:   pick_en = ctl;
      ES_CTL_N: pick_en = ~ctl;
      ES_ON:    pick_en = 1'b1;
      default:  pick_en = dsrc;
    endcase
  endfunction

  always_comb begin
    rt[0]     = route_a;
    rt[1]     = route_b;
    rt[2]     = route_c;
    dec_en    = dec_out & (oe_ctl | ~dec_gate);
    grp_en[0] = pick_en(ensel_a, oe_ctl, dec_en);
    grp_en[1] = pick_en(ensel_b, oe_ctl, dec_en);
    grp_en[2] = 1'b1;
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    lane_group #(.W(GW[g])) u_grp (
      .is_dec (grp_mode[g]),
      .route  (rt[g]),
      .en     (grp_en[g]),
      .l_in   (l_in [GOFF[g] +: GW[g]]),
      .r_in   (r_in [GOFF[g] +: GW[g]]),
      .c_in   (c_in [GOFF[g] +: GW[g]]),
      .l_out  (l_out[GOFF[g] +: GW[g]]),
      .l_oe   (l_oe [GOFF[g] +: GW[g]]),
      .r_out  (r_out[GOFF[g] +: GW[g]]),
      .r_oe   (r_oe [GOFF[g] +: GW[g]])
    );
  end

  always_comb begin
    // R5: buffering pair with a live route always drives
    a_r5_pair_on: assert (grp_mode[2] || (route_c > 3'd4) ||
                          ((l_oe[9:8] | r_oe[9:8]) != 2'b00))
      else $error("pair group not driving");
    // R8: all-buffer decode is a constant set only by combiner type and inversion
    a_r8_const: assert ((grp_mode != 3'b000) || (dec_out == (comb_or == dec_inv)))
      else $error("all-buffer decode not constant");
    // R4: decoder-sourced nibble is off while the decode output is low
    a_r4_dec_off: assert (!(ensel_a == 2'd3 && !dec_out) ||
                          ((l_oe[3:0] | r_oe[3:0]) == 4'h0))
      else $error("nibble A drives with decode low");
    // R9: gated decoder enable is off while the shared control is low
    a_r9_gate_off: assert (!(ensel_b == 2'd3 && dec_gate && !oe_ctl) ||
                           ((l_oe[7:4] | r_oe[7:4]) == 4'h0))
      else $error("nibble B drives with gate low");
  end
endmodule

// File: tb/sim_bufdec_cell.sv
`timescale 1ns/1ps
module sim_bufdec_cell;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [2:0] mode;
    logic [2:0] ra, rb, rc;
    logic [1:0] ta, tb;
    logic       gate, cor, cinv, ctl;
    logic [9:0] lin, rin, cin;
    logic       xdec;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 3'd0, 3'd1, 3'd2, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 10'h2A5, 10'h15A, 10'h3C3, 1'b1},
    '{3'd0, 3'd1, 3'd0, 3'd3, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 10'h0F0, 10'h30F, 10'h155, 1'b0},
    '{3'd0, 3'd2, 3'd3, 3'd4, 2'd2, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 10'h111, 10'h222, 10'h2DB, 1'b0},
    '{3'd0, 3'd4, 3'd4, 3'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 10'h3FF, 10'h000, 10'h1E7, 1'b1},
    '{3'd7, 3'd0, 3'd0, 3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 10'h3FF, 10'h3FF, 10'h3FF, 1'b1},
    '{3'd7, 3'd4, 3'd4, 3'd4, 2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 10'h3FF, 10'h3FF, 10'h3FE, 1'b0},
    '{3'd7, 3'd1, 3'd1, 3'd1, 2'd2, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 10'h155, 10'h2AA, 10'h00F, 1'b1},
    '{3'd7, 3'd0, 3'd2, 3'd3, 2'd0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 10'h155, 10'h2AA, 10'h0F7, 1'b0},
    '{3'd1, 3'd0, 3'd4, 3'd3, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 10'h0A5, 10'h35A, 10'h00F, 1'b1},
    '{3'd1, 3'd0, 3'd4, 3'd3, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 10'h0A5, 10'h35A, 10'h00E, 1'b0},
    '{3'd4, 3'd1, 3'd2, 3'd0, 2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 10'h2C3, 10'h13C, 10'h300, 1'b1},
    '{3'd3, 3'd0, 3'd0, 3'd1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 10'h000, 10'h2FF, 10'h0FF, 1'b0},
    '{3'd1, 3'd0, 3'd3, 3'd2, 2'd0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 10'h1F0, 10'h20F, 10'h00F, 1'b1},
    '{3'd2, 3'd0, 3'd0, 3'd4, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 10'h3A5, 10'h05A, 10'h0F0, 1'b1}
  };

  logic [2:0] grp_mode, route_a, route_b, route_c;
  logic [1:0] ensel_a, ensel_b;
  logic       dec_gate, comb_or, dec_inv, oe_ctl;
  logic [9:0] l_in, r_in, c_in, l_out, l_oe, r_out, r_oe;
  logic       dec_out;

  bufdec_cell u0 (
    .grp_mode(grp_mode), .route_a(route_a), .route_b(route_b), .route_c(route_c),
    .ensel_a(ensel_a), .ensel_b(ensel_b), .dec_gate(dec_gate), .comb_or(comb_or),
    .dec_inv(dec_inv), .oe_ctl(oe_ctl), .l_in(l_in), .r_in(r_in), .c_in(c_in),
    .l_out(l_out), .l_oe(l_oe), .r_out(r_out), .r_oe(r_oe), .dec_out(dec_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  function automatic logic sel_en(logic [1:0] s, logic ctl, logic d, logic gate);
    if (s == 2'd0) return ctl;
    if (s == 2'd1) return !ctl;
    if (s == 2'd2) return 1'b1;
    return gate ? (d && ctl) : d;
  endfunction

  // reference built from the requirements: {l_out, l_oe, r_out, r_oe, dec}
  function automatic logic [40:0] model(vec_t v);
    logic [9:0] lo, loe, ro, roe;
    logic [2:0] t, en;
    logic [2:0] rt;
    logic       acc;
    int         g;
    lo = '0; loe = '0; ro = '0; roe = '0;
    t[0] = &v.cin[3:0];
    t[1] = &v.cin[7:4];
    t[2] = &v.cin[9:8];
    acc = !v.cor;
    for (int k = 0; k < 3; k++)
      if (v.mode[k]) acc = v.cor ? (acc | t[k]) : (acc & t[k]);
    acc = acc ^ v.cinv;
    en[0] = sel_en(v.ta, v.ctl, acc, v.gate);
    en[1] = sel_en(v.tb, v.ctl, acc, v.gate);
    en[2] = 1'b1;
    for (int i = 0; i < 10; i++) begin
      g  = (i < 4) ? 0 : ((i < 8) ? 1 : 2);
      rt = (g == 0) ? v.ra : ((g == 1) ? v.rb : v.rc);
      if (!v.mode[g] && en[g]) begin
        if (rt == 3'd0) begin ro[i] = v.lin[i]; roe[i] = 1'b1; end
        if (rt == 3'd1) begin lo[i] = v.rin[i]; loe[i] = 1'b1; end
        if (rt == 3'd2 || rt == 3'd4) begin lo[i] = v.cin[i]; loe[i] = 1'b1; end
        if (rt == 3'd3 || rt == 3'd4) begin ro[i] = v.cin[i]; roe[i] = 1'b1; end
      end
    end
    return {lo, loe, ro, roe, acc};
  endfunction

  task automatic drive(vec_t v);
    @(negedge clk);
    grp_mode = v.mode; route_a = v.ra; route_b = v.rb; route_c = v.rc;
    ensel_a = v.ta; ensel_b = v.tb; dec_gate = v.gate; comb_or = v.cor;
    dec_inv = v.cinv; oe_ctl = v.ctl; l_in = v.lin; r_in = v.rin; c_in = v.cin;
    #5;
  endtask

  task automatic chk(string tag, string what, logic [9:0] act, logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag, vec_t v);
    logic [40:0] e;
    e = model(v);
    chk(tag, "l_out", l_out, e[40:31]);
    chk(tag, "l_oe",  l_oe,  e[30:21]);
    chk(tag, "r_out", r_out, e[20:11]);
    chk(tag, "r_oe",  r_oe,  e[10:1]);
    chk(tag, "dec",   {9'b0, dec_out}, {9'b0, e[0]});
  endtask

  initial begin
    vec_t v;
    // reset-like state: all configuration zero
    v = '0;
    v.lin = 10'h2C9;
    drive(v);
    chk("R2", "rst r_out", r_out, 10'h200);
    chk("R4", "rst r_oe",  r_oe,  10'h300);
    chk("R3", "rst l_out", l_out, 10'h000);
    chk("R8", "rst dec",   {9'b0, dec_out}, 10'h001);

    // vector table: hand decode values plus model for lanes
    for (int n = 0; n < NV; n++) begin
      drive(TBL[n]);
      chk("R7", "table dec", {9'b0, dec_out}, {9'b0, TBL[n].xdec});
      chk_all("R1/R2/R6", TBL[n]);
    end

    // sweep every mode, combiner, inversion, ctl and central pattern
    for (int m = 0; m < 8; m++)
      for (int o = 0; o < 2; o++)
        for (int iv = 0; iv < 2; iv++)
          for (int c = 0; c < 2; c++)
            for (int p = 0; p < 4; p++) begin
              v = '0;
              v.mode = 3'(m); v.cor = 1'(o); v.cinv = 1'(iv); v.ctl = 1'(c);
              v.ra = 3'((m + p) % 5); v.rb = 3'((m + 2 * p + 1) % 5); v.rc = 3'(p);
              v.ta = 2'(p); v.tb = 2'(3 - p); v.gate = 1'(p & 1);
              v.lin = 10'h19B; v.rin = 10'h264;
              v.cin = (p == 0) ? 10'h3FF : (p == 1) ? 10'h000 : (p == 2) ? 10'h0F0 : 10'h30F;
              drive(v);
              chk_all("R6/R7", v);
            end

    // R2: reserved route codes drive nothing
    for (int r = 5; r < 8; r++) begin
      v = '0; v.ra = 3'(r); v.rb = 3'(r); v.rc = 3'(r); v.ta = 2'd2; v.tb = 2'd2;
      v.lin = 10'h3FF; v.rin = 10'h3FF; v.cin = 10'h3FF;
      drive(v);
      chk("R2", "reserved l_oe", l_oe, 10'h000);
      chk("R2", "reserved r_oe", r_oe, 10'h000);
    end

    // R5: pair ignores shared control
    for (int c = 0; c < 2; c++) begin
      v = '0; v.rc = 3'd4; v.ctl = 1'(c); v.cin = 10'h200;
      drive(v);
      chk("R5", "pair l_oe", l_oe & 10'h300, 10'h300);
      chk("R5", "pair l_out", l_out & 10'h300, 10'h200);
    end

    // R10: nibble A on ctl, nibble B on decode from group C, same evaluation
    v = '0; v.mode = 3'd4; v.ta = 2'd0; v.tb = 2'd3; v.ctl = 1'b1;
    v.lin = 10'h0A5; v.cin = 10'h300;
    drive(v);
    chk("R10", "both on r_oe", r_oe, 10'h0FF);
    chk("R10", "both on r_out", r_out, 10'h0A5);
    v.cin = 10'h100;
    drive(v);
    chk("R10", "B off r_oe", r_oe, 10'h00F);
    chk("R10", "B off r_out", r_out, 10'h005);

    // R9: gating blocks decode enable when ctl low, passes when high
    v = '0; v.mode = 3'd1; v.tb = 2'd3; v.gate = 1'b1; v.rb = 3'd2;
    v.cin = 10'h0FF; v.ctl = 1'b0;
    drive(v);
    chk("R9", "gated off l_oe", l_oe, 10'h000);
    v.ctl = 1'b1;
    drive(v);
    chk("R9", "gated on l_oe", l_oe, 10'h0F0);
    chk("R9", "gated on l_out", l_out, 10'h0F0);

    // R1: all-decoder config with live routes drives nothing
    v = '0; v.mode = 3'd7; v.ra = 3'd4; v.rb = 3'd4; v.rc = 3'd4; v.ta = 2'd2; v.tb = 2'd2;
    v.cin = 10'h3FF;
    drive(v);
    chk("R1", "alldec oe", l_oe | r_oe, 10'h000);
    chk("R1", "alldec out", l_out | r_out, 10'h000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule